// File: doc/BRIEF.md
# Synchronous Burst Read Sequencer

This block controls the memory side of a synchronous burst read from an array organised in words. A host places a start address on the bus, holds the address strobe and a clock-run qualifier high for one clock edge, and the sequencer captures the address and the burst configuration at that edge. It then counts an initial latency and hands back one word per running clock in linear order. A WAIT output is high on each clock where the word on the data bus is new and valid. Bursts have a fixed length of 4, 8 or 16 words. Each burst either wraps inside its aligned window or runs straight on across 16-word lines.

When a no-wrap burst starts close to the end of a line, it stalls once at the line boundary for as many cycles as the initial latency. The host can park a burst by halting the clock (clk_run low) and dropping output enable. Restarting both continues the burst from the word where it stopped. The array sits outside the block and is a registered read port: after each clock edge at which arr_ren is high, arr_rdata holds the word at arr_addr, and it keeps that value while arr_ren is low.

Top module: `burst_rd_seq`

## Requirements
- R1: The start address, latency, length code and wrap bit are captured only at a clock edge where chip_en, addr_vld and clk_run are all high. Changes to the configuration inputs at any other edge have no effect on the burst in progress.
- R2: With latency L taken from cfg_lat (2 to 7; codes 0 and 1 act as 2), the first word is valid after the L-th running clock edge that follows the capture edge.
- R3: cfg_len code 0 gives 4 words, code 1 gives 8 and codes 2 and 3 give 16. After the last word, wait_o stays low until a new address is captured.
- R4: With cfg_wrap = 0, word i is read from start_addr + i and crosses line boundaries.
- R5: With cfg_wrap = 1 and N words, word i is read from the start address with its low log2(N) bits replaced by (start + i) mod N. A wrapping burst never stalls.
- R6: With cfg_wrap = 0 and start_addr[3:0] in 13..15, the word at the first 16-word boundary arrives L+1 running edges after the word before it. Offsets 0..12 never stall.
- R7: wait_o is high after exactly those running edges that present a new word, and then data_o equals the array word for the expected address.
- R8: wait_oe and data_oe are low whenever chip_en or out_en is low.
- R9: While clk_run is low, the sequencer does not advance, no array read is issued and the last word is kept. When the clock is restarted, the burst continues with the next word.
- R10: chip_en low at a clock edge ends the burst. The outputs then stay disabled until a new address is captured.
- R11: A synchronous active-low reset returns the sequencer to idle, with data_oe, wait_oe and wait_o low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| chip_en | input | 1 | Chip enable, active high |
| out_en | input | 1 | Output enable, active high |
| addr_vld | input | 1 | Address strobe; capture at a running edge while high |
| clk_run | input | 1 | High when the burst clock is running; low halts the burst |
| start_addr | input | AW | Burst start word address |
| cfg_lat | input | LAT_W | Initial latency in cycles |
| cfg_len | input | 2 | Burst length code |
| cfg_wrap | input | 1 | 1 = wrap inside window, 0 = linear no-wrap |
| arr_ren | output | 1 | Array read request |
| arr_addr | output | AW | Array read address |
| arr_rdata | input | DW | Registered array read data |
| data_o | output | DW | Burst data, zero when disabled |
| data_oe | output | 1 | Data bus drive enable |
| wait_o | output | 1 | High when data_o holds a new valid word |
| wait_oe | output | 1 | WAIT drive enable |

## Verification
The hardest case to reach is the single boundary stall. It needs a no-wrap burst whose start offset falls in the last three words of a line, and it has to be checked against every latency, since the gap length is the latency itself. The bench sweeps every offset of a line for every latency, length code and wrap setting, and it scrambles the configuration inputs right after capture. Suspends are placed both inside the initial latency and in the middle of the data phase, and the held word is checked before the burst moves on.

// File: rtl/brs_pkg.sv
package brs_pkg;
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_LAT   = 3'd1,
        ST_DATA  = 3'd2,
        ST_STALL = 3'd3,
        ST_DONE  = 3'd4
    } st_e;

    // low-bit mask of the aligned burst window for a length code
    function automatic logic [3:0] len_mask(input logic [1:0] code);
        case (code)
            2'd0:    len_mask = 4'd3;
            2'd1:    len_mask = 4'd7;
            default: len_mask = 4'd15;
        endcase
    endfunction
endpackage

// File: rtl/brs_cfg_decode.sv
module brs_cfg_decode #(
    parameter int LAT_W   = 3,
    parameter int CNT_W   = 5,
    parameter int MIN_LAT = 2
) (
    input  logic [LAT_W-1:0] lat_raw,
    input  logic [1:0]       len_code,
    output logic [LAT_W-1:0] lat_eff,
    output logic [CNT_W-1:0] nwords
);
    always_comb begin
        lat_eff = (lat_raw < LAT_W'(MIN_LAT)) ? LAT_W'(MIN_LAT) : lat_raw;
        case (len_code)
            2'd0:    nwords = CNT_W'(4);
            2'd1:    nwords = CNT_W'(8);
            default: nwords = CNT_W'(16);
        endcase
    end
endmodule

// File: rtl/brs_addr_step.sv
module brs_addr_step #(
    parameter int AW = 16
) (
    input  logic [AW-1:0] cur,
    input  logic          wrap,
    input  logic [1:0]    len_code,
    output logic [AW-1:0] nxt
);
    logic [AW-1:0] msk;
    logic [AW-1:0] inc;

    always_comb begin
        msk = AW'(brs_pkg::len_mask(len_code));
        inc = cur + AW'(1);
        nxt = wrap ? ((cur & ~msk) | (inc & msk)) : inc;
    end
endmodule

// File: rtl/brs_out_gate.sv
module brs_out_gate #(
    parameter int DW = 16
) (
    input  logic          chip_en,
    input  logic          out_en,
    input  logic          active,
    input  logic          vld,
    input  logic [DW-1:0] rdata,
    output logic [DW-1:0] data_o,
    output logic          data_oe,
    output logic          wait_o,
    output logic          wait_oe
);
    logic drive;

    always_comb begin
        drive   = chip_en & out_en & active;
        data_oe = drive;
        wait_oe = drive;
        wait_o  = drive & vld;
        data_o  = drive ? rdata : '0;
    end
endmodule

// File: rtl/burst_rd_seq.sv
module burst_rd_seq #(
    parameter int AW         = 16,
    parameter int DW         = 16,
    parameter int LAT_W      = 3,
    parameter int LINE_W     = 4,
    parameter int STALL_FROM = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             chip_en,
    input  logic             out_en,
    input  logic             addr_vld,
    input  logic             clk_run,
    input  logic [AW-1:0]    start_addr,
    input  logic [LAT_W-1:0] cfg_lat,
    input  logic [1:0]       cfg_len,
    input  logic             cfg_wrap,
    output logic             arr_ren,
    output logic [AW-1:0]    arr_addr,
    input  logic [DW-1:0]    arr_rdata,
    output logic [DW-1:0]    data_o,
    output logic             data_oe,
    output logic             wait_o,
    output logic             wait_oe
);
    import brs_pkg::*;

    localparam int IDX_W = LINE_W + 1;

    typedef struct packed {
        st_e              st;
        logic [AW-1:0]    cur;
        logic [AW-1:0]    base;
        logic [IDX_W-1:0] idx;
        logic [LAT_W-1:0] cnt;
        logic [LAT_W-1:0] lat;
        logic [1:0]       lenc;
        logic             wrap;
        logic             arm;
        logic             vld;
    } seq_t;

    seq_t r_d, r_q;

    logic [LAT_W-1:0] lat_in;
    logic [IDX_W-1:0] nwords;
    logic [AW-1:0]    nxt_addr;
    logic             ren_d;

    brs_cfg_decode #(.LAT_W(LAT_W), .CNT_W(IDX_W), .MIN_LAT(2)) dec_i (
        .lat_raw (cfg_lat),
        .len_code(r_q.lenc),
        .lat_eff (lat_in),
        .nwords  (nwords)
    );

    brs_addr_step #(.AW(AW)) step_i (
        .cur     (r_q.cur),
        .wrap    (r_q.wrap),
        .len_code(r_q.lenc),
        .nxt     (nxt_addr)
    );

    brs_out_gate #(.DW(DW)) gate_i (
        .chip_en(chip_en),
        .out_en (out_en),
        .active (r_q.st != ST_IDLE),
        .vld    (r_q.vld),
        .rdata  (arr_rdata),
        .data_o (data_o),
        .data_oe(data_oe),
        .wait_o (wait_o),
        .wait_oe(wait_oe)
    );

    always_comb begin
        r_d   = r_q;
        ren_d = 1'b0;
        if (!chip_en) begin
            r_d = '0;
        end else if (clk_run) begin
            if (addr_vld) begin
                r_d.st   = ST_LAT;
                r_d.cur  = start_addr;
                r_d.base = start_addr & ~AW'(len_mask(cfg_len));
                r_d.idx  = '0;
                r_d.lat  = lat_in;
                r_d.cnt  = lat_in - LAT_W'(1);
                r_d.lenc = cfg_len;
                r_d.wrap = cfg_wrap;
                r_d.arm  = !cfg_wrap &&
                           (start_addr[LINE_W-1:0] >= LINE_W'(STALL_FROM));
                r_d.vld  = 1'b0;
            end else begin
                case (r_q.st)
                    ST_LAT, ST_STALL: begin
                        if (r_q.cnt == '0) begin
                            ren_d   = 1'b1;
                            r_d.cur = nxt_addr;
                            r_d.idx = r_q.idx + IDX_W'(1);
                            r_d.vld = 1'b1;
                            r_d.st  = ST_DATA;
                        end else begin
                            r_d.cnt = r_q.cnt - LAT_W'(1);
                            r_d.vld = 1'b0;
                        end
                    end
                    ST_DATA: begin
                        if (r_q.idx == nwords) begin
                            r_d.st  = ST_DONE;
                            r_d.vld = 1'b0;
                        end else if (r_q.arm && (r_q.cur[LINE_W-1:0] == '0)) begin
                            r_d.st  = ST_STALL;
                            r_d.cnt = r_q.lat - LAT_W'(1);
                            r_d.arm = 1'b0;
                            r_d.vld = 1'b0;
                        end else begin
                            ren_d   = 1'b1;
                            r_d.cur = nxt_addr;
                            r_d.idx = r_q.idx + IDX_W'(1);
                            r_d.vld = 1'b1;
                        end
                    end
                    ST_DONE: r_d.vld = 1'b0;
                    default: r_d = r_q;
                endcase
            end
        end
    end

    assign arr_ren  = ren_d;
    assign arr_addr = r_q.cur;

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end
endmodule

// File: rtl/burst_rd_seq_chk.sv
module burst_rd_seq_chk #(
    parameter int AW    = 16,
    parameter int IDX_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             chip_en,
    input logic             clk_run,
    input logic             arr_ren,
    input brs_pkg::st_e     st,
    input logic [AW-1:0]    cur,
    input logic [AW-1:0]    base,
    input logic [IDX_W-1:0] idx,
    input logic [1:0]       lenc,
    input logic             wrap,
    input logic             arm,
    input logic             vld
);
    import brs_pkg::*;

    logic [IDX_W-1:0] nw;
    logic [AW-1:0]    msk;
    always_comb begin
        nw  = (lenc == 2'd0) ? IDX_W'(4) : (lenc == 2'd1) ? IDX_W'(8) : IDX_W'(16);
        msk = AW'(len_mask(lenc));
    end

    AST_RESET_IDLE: assert property (@(posedge clk) !rst_n |=> (st == ST_IDLE) && !vld); // R11
    AST_CE_ENDS: assert property (@(posedge clk) disable iff (!rst_n) !chip_en |=> st == ST_IDLE); // R10
    AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_run && chip_en) |=> $stable(cur) && $stable(idx) && $stable(vld) && $stable(st)); // R9
    AST_HALT_NO_READ: assert property (@(posedge clk) disable iff (!rst_n) !clk_run |-> !arr_ren); // R9
    AST_FETCH_VALID: assert property (@(posedge clk) disable iff (!rst_n) arr_ren |=> vld); // R7
    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        vld |-> (idx >= IDX_W'(1)) && (idx <= nw)); // R3
    AST_WRAP_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && st != ST_IDLE) |-> ((cur & ~msk) == base)); // R5
    AST_WRAP_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |-> st != ST_STALL); // R5
    AST_STALL_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st == ST_STALL) |-> $past(arm) && !arm); // R6
endmodule

bind burst_rd_seq burst_rd_seq_chk #(.AW(AW), .IDX_W(IDX_W)) chk_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .chip_en(chip_en),
    .clk_run(clk_run),
    .arr_ren(arr_ren),
    .st     (r_q.st),
    .cur    (r_q.cur),
    .base   (r_q.base),
    .idx    (r_q.idx),
    .lenc   (r_q.lenc),
    .wrap   (r_q.wrap),
    .arm    (r_q.arm),
    .vld    (r_q.vld)
);

// File: tb/burst_rd_seq_tb_top.sv
`timescale 1ns/1ps
module burst_rd_seq_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        chip_en = 1'b1;
    logic        out_en = 1'b1;
    logic        addr_vld = 1'b0;
    logic        clk_run = 1'b1;
    logic [15:0] start_addr = '0;
    logic [2:0]  cfg_lat = 3'd2;
    logic [1:0]  cfg_len = 2'd0;
    logic        cfg_wrap = 1'b0;
    logic        arr_ren;
    logic [15:0] arr_addr;
    logic [15:0] arr_rdata = '0;
    logic [15:0] data_o;
    logic        data_oe, wait_o, wait_oe;

    int n_cmp = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    burst_rd_seq dut_i (
        .clk(clk), .rst_n(rst_n), .chip_en(chip_en), .out_en(out_en),
        .addr_vld(addr_vld), .clk_run(clk_run), .start_addr(start_addr),
        .cfg_lat(cfg_lat), .cfg_len(cfg_len), .cfg_wrap(cfg_wrap),
        .arr_ren(arr_ren), .arr_addr(arr_addr), .arr_rdata(arr_rdata),
        .data_o(data_o), .data_oe(data_oe), .wait_o(wait_o), .wait_oe(wait_oe)
    );

    function automatic logic [15:0] word_of(input logic [15:0] a);
        return a ^ 16'h5A3C;
    endfunction

    // registered array read port
    always @(posedge clk) if (arr_ren) arr_rdata <= word_of(arr_addr);

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic run_burst(input int start, input int lat, input int lenc,
                             input int wrap, input int susp_at);
        int L, n, off, msk, base, p, last;
        bit armed, ev;
        int edges[16];
        int addrs[16];
        L = (lat < 2) ? 2 : lat;
        n = (lenc == 0) ? 4 : (lenc == 1) ? 8 : 16;
        off = start & 15;
        armed = (wrap == 0) && (off >= 13);
        msk = n - 1;
        base = start & ~msk;
        for (int i = 0; i < n; i++) begin
            addrs[i] = wrap ? (base | ((start + i) & msk)) : ((start + i) & 16'hFFFF);
            if (i == 0) edges[i] = L;
            else edges[i] = edges[i-1] + ((armed && (((start + i) & 15) == 0)) ? L + 1 : 1);
        end
        @(negedge clk);
        chip_en = 1'b1; out_en = 1'b1; clk_run = 1'b1; addr_vld = 1'b1;
        start_addr = 16'(start); cfg_lat = 3'(lat); cfg_len = 2'(lenc); cfg_wrap = wrap[0];
        @(posedge clk);
        @(negedge clk);
        // R1: scramble configuration after capture; must not matter
        addr_vld = 1'b0;
        cfg_lat = 3'(~lat); cfg_len = 2'(~lenc); cfg_wrap = ~wrap[0]; start_addr = 16'(~start);
        chk(wait_oe == 1'b1, "R8 wait driven while enabled", int'(wait_oe), 1);
        p = 0;
        last = edges[n-1] + 2;
        for (int k = 1; k <= last; k++) begin
            if (k == susp_at) begin
                for (int h = 0; h < 3; h++) begin
                    clk_run = 1'b0; out_en = 1'b0;
                    @(posedge clk);
                    @(negedge clk);
                    chk(!wait_oe && !data_oe, "R8 outputs off while out_en low",
                        int'({wait_oe, data_oe}), 0);
                end
                clk_run = 1'b1; out_en = 1'b1;
                #1;
                ev = (p > 0) && (edges[p-1] == k - 1);
                chk(wait_o == ev, "R9 wait held across suspend", int'(wait_o), int'(ev));
                if (ev) chk(data_o == word_of(16'(addrs[p-1])), "R9 word held across suspend",
                            int'(data_o), int'(word_of(16'(addrs[p-1]))));
            end
            @(posedge clk);
            @(negedge clk);
            ev = (p < n) && (edges[p] == k);
            if (p >= n) chk(wait_o == 1'b0, "R3 wait low after last word", int'(wait_o), 0);
            else if (p == 0) chk(wait_o == ev, "R2 initial latency wait", int'(wait_o), int'(ev));
            else chk(wait_o == ev, "R7 wait per edge", int'(wait_o), int'(ev));
            if (ev) begin
                if (wrap != 0)
                    chk(data_o == word_of(16'(addrs[p])), "R5 wrap data", int'(data_o), int'(word_of(16'(addrs[p]))));
                else if (armed)
                    chk(data_o == word_of(16'(addrs[p])), "R6 stall path data", int'(data_o), int'(word_of(16'(addrs[p]))));
                else
                    chk(data_o == word_of(16'(addrs[p])), "R4 linear data", int'(data_o), int'(word_of(16'(addrs[p]))));
                p++;
            end
        end
        chk(p == n, "R3 word count", p, n);
        chip_en = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk(!data_oe && !wait_oe, "R10 chip_en low disables", int'({data_oe, wait_oe}), 0);
        chip_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk(!data_oe && !wait_o, "R10 idle until new capture", int'({data_oe, wait_o}), 0);
    endtask

    initial begin
        #(4 * 150000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(!data_oe && !wait_oe && !wait_o, "R11 reset state", int'({data_oe, wait_oe, wait_o}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!data_oe && !wait_o, "R11 idle after reset", int'({data_oe, wait_o}), 0);

        for (int lat = 2; lat <= 7; lat++)
            for (int lc = 0; lc <= 2; lc++)
                for (int w = 0; w <= 1; w++)
                    for (int off = 0; off < 16; off++)
                        run_burst(16'h0230 + off, lat, lc, w, 0);

        // latency clamp and length code 3
        run_burst(16'h0340, 0, 3, 0, 0);
        run_burst(16'h034E, 1, 3, 0, 0);
        run_burst(16'h035D, 0, 3, 1, 0);

        // suspend during latency and mid-burst, including around the stall
        for (int lat = 2; lat <= 7; lat++) begin
            run_burst(16'h0400, lat, 1, 0, 1);
            run_burst(16'h040E, lat, 2, 0, lat + 2);
            run_burst(16'h0415, lat, 1, 1, lat + 3);
            run_burst(16'h042D, lat, 0, 0, lat + 1);
        end

        // R11 reset in the middle of a burst
        @(negedge clk);
        addr_vld = 1'b1; start_addr = 16'h0500; cfg_lat = 3'd2; cfg_len = 2'd2; cfg_wrap = 1'b0;
        @(posedge clk);
        @(negedge clk);
        addr_vld = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk(!data_oe && !wait_o && !wait_oe, "R11 reset mid-burst", int'({data_oe, wait_o, wait_oe}), 0);
        rst_n = 1'b1;

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule